// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block sits beside the execute stage of a 32-bit core and takes over the program counter whenever an exception is taken or an exception handler returns. Seven request lines arrive from the rest of the core: the reset request, undefined instruction, software interrupt, prefetch abort, data abort, normal interrupt and fast interrupt. The block also sees the current PC, the live status word and a strobe that marks the cycle in which the instruction in execute completes. When it accepts an exception, it chooses one request by a fixed priority. It stores the live status word and the return PC in the storage banked for the target mode. It then issues a redirect that carries the slot address in the vector table and the new status word for the core to load.

A return request is sampled together with the completion strobe. The block reads the banked copies that belong to the mode in the live status word and issues a redirect that restores both. The core owns the live status register and loads the redirect's status word into it. This block keeps only the banked saved-status and link copies.

Redirect outputs are control pins and carry no back-pressure. `redir_valid` is high for exactly one cycle for each accepted event, and the core must act on it in that cycle.

Top module: `exc_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released with no request, `redir_valid`, `redir_is_return`, `redir_pc` and `redir_status` are all zero.
- R2: An accepted exception redirects to the vector base (default 0) plus a slot offset: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, interrupt 0x18, fast interrupt 0x1C. Offset 0x14 is never produced.
- R3: A non-reset request is accepted only in a cycle where `instr_done` is 1. A reset request is accepted in any cycle. The redirect appears in the cycle after acceptance and lasts one cycle.
- R4: When several requests are accepted together, the winner is chosen in this order, highest first: reset, data abort, fast interrupt, interrupt, prefetch abort, undefined, software interrupt.
- R5: The interrupt request is ignored while status bit 7 is 1. The fast interrupt request is ignored while status bit 6 is 1.
- R6: The status word of an exception redirect equals the live status word with these changes: bits [4:0] hold the mode code (fast interrupt 10001, interrupt 10010, reset and software interrupt 10011, both aborts 10111, undefined 11011); bit 5 is cleared; bit 7 is set; bit 6 is set on a fast interrupt entry and unchanged otherwise. Bits [31:8], which include the flags in [31:27], pass through unchanged.
- R7: On entry, the live status word and `cur_pc` are stored in the saved-status and link copies of the target mode. Each of the five exception modes has its own copies, so a nested entry into another mode leaves the outer copies intact.
- R8: When `ret_req` and `instr_done` are both 1 and the live mode owns a bank, the redirect carries that bank's link copy as the PC and its saved-status copy as the status word, with `redir_is_return` set to 1.
- R9: A return request is ignored when status bit 5 is 1, or when the live mode code is not one of the five exception modes.
- R10: If an exception is accepted in the same cycle as a return request, the exception is taken and the return is discarded. The banks of all other modes are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset |
| req_rst | input | 1 | Reset exception request |
| req_und | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_dabt | input | 1 | Data abort request |
| req_irq | input | 1 | Normal interrupt request |
| req_fiq | input | 1 | Fast interrupt request |
| instr_done | input | 1 | The instruction in execute completes this cycle |
| ret_req | input | 1 | Exception return request |
| cur_pc | input | 32 | Return address to save on entry |
| cur_status | input | 32 | Live status word |
| redir_valid | output | 1 | One-cycle redirect strobe |
| redir_is_return | output | 1 | The redirect is a return |
| redir_pc | output | 32 | PC to load |
| redir_status | output | 32 | Status word to load |

## Verification
The collision to provoke is an exception and a return in the same cycle. It is driven by raising a software interrupt and `ret_req` together with `instr_done` while the live mode is the interrupt mode. The expected result is a supervisor entry at 0x08 with no return flag. A return from supervisor mode must then give back the interrupted PC and status. A later return from the interrupt mode must still give back the copies saved before the collision, which shows that the discarded return changed no bank.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int MODE_W = 5;
  localparam int NEXC   = 7;
  localparam int NBANK  = 5;
  localparam int BANK_W = $clog2(NBANK);
  localparam int OFF_W  = 5;

  localparam int BIT_I = 7;
  localparam int BIT_F = 6;
  localparam int BIT_T = 5;

  // priority order: lower value wins
  typedef enum logic [2:0] {
    EX_RST  = 3'd0,
    EX_DABT = 3'd1,
    EX_FIQ  = 3'd2,
    EX_IRQ  = 3'd3,
    EX_PABT = 3'd4,
    EX_UND  = 3'd5,
    EX_SWI  = 3'd6
  } exc_e;

  localparam logic [MODE_W-1:0] MD_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MD_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MD_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MD_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MD_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MD_UND = 5'b11011;

  typedef struct packed {
    logic              ok;
    logic [BANK_W-1:0] idx;
  } bank_sel_t;

  function automatic logic [OFF_W-1:0] slot_of(exc_e e);
    case (e)
      EX_RST:  slot_of = 5'h00;
      EX_UND:  slot_of = 5'h04;
      EX_SWI:  slot_of = 5'h08;
      EX_PABT: slot_of = 5'h0C;
      EX_DABT: slot_of = 5'h10;
      EX_IRQ:  slot_of = 5'h18;
      default: slot_of = 5'h1C;
    endcase
  endfunction

  function automatic logic [MODE_W-1:0] mode_of(exc_e e);
    case (e)
      EX_FIQ:           mode_of = MD_FIQ;
      EX_IRQ:           mode_of = MD_IRQ;
      EX_PABT, EX_DABT: mode_of = MD_ABT;
      EX_UND:           mode_of = MD_UND;
      default:          mode_of = MD_SVC;
    endcase
  endfunction

  function automatic bank_sel_t bank_of(logic [MODE_W-1:0] m);
    bank_sel_t b;
    b.ok = 1'b1;
    case (m)
      MD_FIQ:  b.idx = BANK_W'(0);
      MD_IRQ:  b.idx = BANK_W'(1);
      MD_SVC:  b.idx = BANK_W'(2);
      MD_ABT:  b.idx = BANK_W'(3);
      MD_UND:  b.idx = BANK_W'(4);
      default: begin b.ok = 1'b0; b.idx = '0; end
    endcase
    return b;
  endfunction
endpackage

// File: rtl/exc_arb.sv
module exc_arb #(
  parameter int NREQ = 7,
  localparam int IW = $clog2(NREQ)
) (
  input  logic [NREQ-1:0] req,
  output logic            any,
  output logic [IW-1:0]   win
);
  // fixed priority, index 0 highest
  always_comb begin
    any = 1'b0;
    win = '0;
    for (int k = NREQ - 1; k >= 0; k--) begin
      if (req[k]) begin
        any = 1'b1;
        win = IW'(k);
      end
    end
  end
endmodule

// File: rtl/exc_entry_word.sv
module exc_entry_word
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] live,
  input  exc_e            kind,
  output logic [XLEN-1:0] word
);
  always_comb begin
    word = live;
    word[MODE_W-1:0] = mode_of(kind);
    word[BIT_T] = 1'b0;
    word[BIT_I] = 1'b1;
    if (kind == EX_FIQ) word[BIT_F] = 1'b1;
  end
endmodule

// File: rtl/exc_bank.sv
module exc_bank
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] wr_idx,
  input  logic [XLEN-1:0]   wr_status,
  input  logic [XLEN-1:0]   wr_link,
  input  logic [BANK_W-1:0] rd_idx,
  output logic [XLEN-1:0]   rd_status,
  output logic [XLEN-1:0]   rd_link
);
  logic [NBANK*XLEN-1:0] stat_flat;
  logic [NBANK*XLEN-1:0] link_flat;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic [XLEN-1:0] stat_q, link_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stat_q <= '0;
        link_q <= '0;
      end else if (wr_en && wr_idx == BANK_W'(g)) begin
        stat_q <= wr_status;
        link_q <= wr_link;
      end
    end
    assign stat_flat[g*XLEN +: XLEN] = stat_q;
    assign link_flat[g*XLEN +: XLEN] = link_q;
  end

  always_comb begin
    rd_status = '0;
    rd_link   = '0;
    for (int k = 0; k < NBANK; k++) begin
      if (rd_idx == BANK_W'(k)) begin
        rd_status = stat_flat[k*XLEN +: XLEN];
        rd_link   = link_flat[k*XLEN +: XLEN];
      end
    end
  end
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] VEC_BASE = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_rst,
  input  logic            req_und,
  input  logic            req_swi,
  input  logic            req_pabt,
  input  logic            req_dabt,
  input  logic            req_irq,
  input  logic            req_fiq,
  input  logic            instr_done,
  input  logic            ret_req,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] cur_status,
  output logic            redir_valid,
  output logic            redir_is_return,
  output logic [XLEN-1:0] redir_pc,
  output logic [XLEN-1:0] redir_status
);
  localparam int IW = $clog2(NEXC);

  logic [NEXC-1:0] eligible;
  logic            take_exc;
  logic [IW-1:0]   win_idx;
  exc_e            win_kind;
  logic [XLEN-1:0] entry_word;
  bank_sel_t       wr_sel, rd_sel;
  logic [XLEN-1:0] bank_status, bank_link;
  logic            take_ret;

  always_comb begin
    eligible          = '0;
    eligible[EX_RST]  = req_rst;
    eligible[EX_DABT] = req_dabt && instr_done;
    eligible[EX_FIQ]  = req_fiq  && instr_done && !cur_status[BIT_F];
    eligible[EX_IRQ]  = req_irq  && instr_done && !cur_status[BIT_I];
    eligible[EX_PABT] = req_pabt && instr_done;
    eligible[EX_UND]  = req_und  && instr_done;
    eligible[EX_SWI]  = req_swi  && instr_done;
  end

  exc_arb #(.NREQ(NEXC)) u_arb (
    .req (eligible),
    .any (take_exc),
    .win (win_idx)
  );

  assign win_kind = exc_e'(win_idx);

  exc_entry_word #(.XLEN(XLEN)) u_word (
    .live (cur_status),
    .kind (win_kind),
    .word (entry_word)
  );

  assign wr_sel = bank_of(mode_of(win_kind));
  assign rd_sel = bank_of(cur_status[MODE_W-1:0]);

  exc_bank #(.XLEN(XLEN)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (take_exc),
    .wr_idx    (wr_sel.idx),
    .wr_status (cur_status),
    .wr_link   (cur_pc),
    .rd_idx    (rd_sel.idx),
    .rd_status (bank_status),
    .rd_link   (bank_link)
  );

  assign take_ret = ret_req && instr_done && !take_exc &&
                    !cur_status[BIT_T] && rd_sel.ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redir_valid     <= 1'b0;
      redir_is_return <= 1'b0;
      redir_pc        <= '0;
      redir_status    <= '0;
    end else begin
      redir_valid     <= take_exc || take_ret;
      redir_is_return <= take_ret;
      if (take_exc) begin
        redir_pc     <= VEC_BASE + XLEN'(slot_of(win_kind));
        redir_status <= entry_word;
      end else if (take_ret) begin
        redir_pc     <= bank_link;
        redir_status <= bank_status;
      end
    end
  end
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] VEC_BASE = '0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_rst,
  input logic            req_und,
  input logic            req_swi,
  input logic            req_pabt,
  input logic            req_dabt,
  input logic            req_irq,
  input logic            req_fiq,
  input logic            instr_done,
  input logic            ret_req,
  input logic [XLEN-1:0] cur_status,
  input logic            redir_valid,
  input logic            redir_is_return,
  input logic [XLEN-1:0] redir_pc,
  input logic [XLEN-1:0] redir_status
);
  logic [XLEN-1:0] off;
  assign off = redir_pc - VEC_BASE;

  AST_SLOT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && !redir_is_return) |-> (off[1:0] == 2'b00 && off <= 32'h1C && off != 32'h14)); // R2
  AST_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!instr_done && !req_rst) |=> !redir_valid); // R3
  AST_RST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    req_rst |=> (redir_valid && !redir_is_return && redir_pc == VEC_BASE)); // R4
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_irq && cur_status[7] && !req_rst && !req_und && !req_swi && !req_pabt &&
     !req_dabt && !req_fiq && !ret_req) |=> !redir_valid); // R5
  AST_T_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && !redir_is_return) |-> (!redir_status[5] && redir_status[7])); // R6
  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && !redir_is_return) |-> (redir_status[XLEN-1:8] == $past(cur_status[XLEN-1:8]))); // R6
  AST_RET_T_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && cur_status[5] && !req_rst && !req_und && !req_swi && !req_pabt &&
     !req_dabt && !req_irq && !req_fiq) |=> !redir_valid); // R9
  AST_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && req_rst) |=> !redir_is_return); // R10
endmodule

bind exc_ctrl exc_ctrl_chk #(.XLEN(XLEN), .VEC_BASE(VEC_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_rst(req_rst), .req_und(req_und), .req_swi(req_swi),
  .req_pabt(req_pabt), .req_dabt(req_dabt), .req_irq(req_irq), .req_fiq(req_fiq),
  .instr_done(instr_done), .ret_req(ret_req), .cur_status(cur_status),
  .redir_valid(redir_valid), .redir_is_return(redir_is_return),
  .redir_pc(redir_pc), .redir_status(redir_status)
);

// File: tb/exc_ctrl_tb.sv
module exc_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_rst = 0, req_und = 0, req_swi = 0, req_pabt = 0, req_dabt = 0, req_irq = 0, req_fiq = 0;
  logic instr_done = 0, ret_req = 0;
  logic [31:0] cur_pc = '0, cur_status = '0;
  logic redir_valid, redir_is_return;
  logic [31:0] redir_pc, redir_status;
  int checks = 0, errors = 0;
  bit done_flag = 0;

  // request bit positions in the bench mask
  localparam int M_RST = 0, M_UND = 1, M_SWI = 2, M_PABT = 3, M_DABT = 4, M_IRQ = 5, M_FIQ = 6;

  always #10 clk = ~clk;

  exc_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_rst(req_rst), .req_und(req_und), .req_swi(req_swi),
    .req_pabt(req_pabt), .req_dabt(req_dabt), .req_irq(req_irq), .req_fiq(req_fiq),
    .instr_done(instr_done), .ret_req(ret_req), .cur_pc(cur_pc), .cur_status(cur_status),
    .redir_valid(redir_valid), .redir_is_return(redir_is_return),
    .redir_pc(redir_pc), .redir_status(redir_status)
  );

  task automatic check(input string tag, input logic ev, input logic [31:0] epc,
                       input logic [31:0] est, input logic eret);
    checks++;
    if (redir_valid !== ev || (ev && (redir_pc !== epc || redir_status !== est ||
        redir_is_return !== eret))) begin
      errors++;
      $display("FAIL %s: got v=%0b pc=%h st=%h ret=%0b, expected v=%0b pc=%h st=%h ret=%0b",
               tag, redir_valid, redir_pc, redir_status, redir_is_return, ev, epc, est, eret);
    end
  endtask

  // drive one cycle at the falling edge, clear, result visible at the next falling edge
  task automatic step(input logic [6:0] m, input logic done, input logic ret,
                      input logic [31:0] pc, input logic [31:0] st);
    @(negedge clk);
    {req_fiq, req_irq, req_dabt, req_pabt, req_swi, req_und, req_rst} = m;
    instr_done = done; ret_req = ret; cur_pc = pc; cur_status = st;
    @(negedge clk);
    {req_fiq, req_irq, req_dabt, req_pabt, req_swi, req_und, req_rst} = '0;
    instr_done = 0; ret_req = 0;
  endtask

  task automatic t_reset;
    checks++;
    if (redir_valid !== 0 || redir_is_return !== 0 || redir_pc !== 0 || redir_status !== 0) begin
      errors++;
      $display("FAIL R1: got v=%0b ret=%0b pc=%h st=%h, expected all zero",
               redir_valid, redir_is_return, redir_pc, redir_status);
    end
    step(7'h0, 1, 0, 32'h100, 32'h10);
    check("R1 idle", 0, 0, 0, 0);
  endtask

  task automatic t_vectors;
    logic [31:0] s;
    s = 32'hF800_0010;
    step(7'h1 << M_RST,  1, 0, 32'h40, s); check("R2 reset slot", 1, 32'h00, 32'hF800_0093, 0);
    step(7'h1 << M_UND,  1, 0, 32'h44, s); check("R2 undef slot", 1, 32'h04, 32'hF800_009B, 0);
    step(7'h1 << M_SWI,  1, 0, 32'h48, s); check("R2 swi slot",   1, 32'h08, 32'hF800_0093, 0);
    step(7'h1 << M_PABT, 1, 0, 32'h4C, s); check("R2 pabt slot",  1, 32'h0C, 32'hF800_0097, 0);
    step(7'h1 << M_DABT, 1, 0, 32'h50, s); check("R2 dabt slot",  1, 32'h10, 32'hF800_0097, 0);
    step(7'h1 << M_IRQ,  1, 0, 32'h54, s); check("R2 irq slot",   1, 32'h18, 32'hF800_0092, 0);
    step(7'h1 << M_FIQ,  1, 0, 32'h58, s); check("R2 fiq slot",   1, 32'h1C, 32'hF800_00D1, 0);
    step(7'h1 << M_SWI,  1, 0, 32'h5C, 32'h0800_0030);
    check("R6 T cleared, Q kept", 1, 32'h08, 32'h0800_0093, 0);
  endtask

  task automatic t_timing;
    step(7'h1 << M_UND, 0, 0, 32'h60, 32'h10); check("R3 no done", 0, 0, 0, 0);
    step(7'h1 << M_RST, 0, 0, 32'h60, 32'h10); check("R3 reset without done", 1, 32'h00, 32'h93, 0);
    @(negedge clk); check("R3 one-cycle pulse", 0, 0, 0, 0);
  endtask

  task automatic t_priority;
    step(7'h7F, 1, 0, 32'h70, 32'h10); check("R4 reset first", 1, 32'h00, 32'h93, 0);
    step(7'h7E, 1, 0, 32'h70, 32'h10); check("R4 dabt next", 1, 32'h10, 32'h97, 0);
    step(7'h6E, 1, 0, 32'h70, 32'h10); check("R4 fiq next", 1, 32'h1C, 32'hD1, 0);
    step(7'h2E, 1, 0, 32'h70, 32'h10); check("R4 irq next", 1, 32'h18, 32'h92, 0);
    step(7'h0E, 1, 0, 32'h70, 32'h10); check("R4 pabt next", 1, 32'h0C, 32'h97, 0);
    step(7'h06, 1, 0, 32'h70, 32'h10); check("R4 undef over swi", 1, 32'h04, 32'h9B, 0);
  endtask

  task automatic t_mask;
    step(7'h1 << M_IRQ, 1, 0, 32'h80, 32'h90); check("R5 irq masked", 0, 0, 0, 0);
    step(7'h1 << M_FIQ, 1, 0, 32'h80, 32'h50); check("R5 fiq masked", 0, 0, 0, 0);
    step((7'h1 << M_FIQ) | (7'h1 << M_IRQ), 1, 0, 32'h80, 32'h50);
    check("R5 irq passes masked fiq", 1, 32'h18, 32'hD2, 0);
    step((7'h1 << M_FIQ) | (7'h1 << M_IRQ), 1, 0, 32'h80, 32'hD0);
    check("R5 both masked", 0, 0, 0, 0);
  endtask

  task automatic t_nested;
    step(7'h1 << M_IRQ, 1, 0, 32'h1000, 32'h4000_0010);
    check("R7 irq entry", 1, 32'h18, 32'h4000_0092, 0);
    step(7'h1 << M_FIQ, 1, 0, 32'h2000, 32'h4000_0092);
    check("R7 nested fiq entry", 1, 32'h1C, 32'h4000_00D1, 0);
    step(7'h0, 1, 1, 32'h1C, 32'h4000_00D1);
    check("R8 return from fiq", 1, 32'h2000, 32'h4000_0092, 1);
    step(7'h0, 1, 1, 32'h18, 32'h4000_0092);
    check("R7 R8 return from irq", 1, 32'h1000, 32'h4000_0010, 1);
  endtask

  task automatic t_ret_block;
    step(7'h0, 1, 1, 32'h90, 32'hB3); check("R9 T set", 0, 0, 0, 0);
    step(7'h0, 1, 1, 32'h90, 32'h10); check("R9 user mode", 0, 0, 0, 0);
    step(7'h0, 1, 1, 32'h90, 32'h1F); check("R9 unbanked mode", 0, 0, 0, 0);
    step(7'h0, 0, 1, 32'h90, 32'h92); check("R8 needs done", 0, 0, 0, 0);
  endtask

  task automatic t_collide;
    step(7'h1 << M_IRQ, 1, 0, 32'h1000, 32'h4000_0010);
    check("R10 setup", 1, 32'h18, 32'h4000_0092, 0);
    step(7'h1 << M_SWI, 1, 1, 32'h3000, 32'h2000_0092);
    check("R10 exception wins", 1, 32'h08, 32'h2000_0093, 0);
    step(7'h0, 1, 1, 32'h08, 32'h2000_0093);
    check("R10 svc return", 1, 32'h3000, 32'h2000_0092, 1);
    step(7'h0, 1, 1, 32'h18, 32'h4000_0092);
    check("R10 irq bank intact", 1, 32'h1000, 32'h4000_0010, 1);
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_reset;
    t_vectors;
    t_timing;
    t_priority;
    t_mask;
    t_nested;
    t_ret_block;
    t_collide;
    finish_run;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run;
  end
endmodule